// File: doc/BRIEF.md
# PLL Lock Status Controller

This block holds the configuration of a frequency synthesizer and tells software when the synthesizer can be used. A single bus write loads four fields: a multiplier, a pre-divider, an output range code and a lock-wait count. The synthesizer itself is not part of the block. Its configuration is driven out as plain registers, together with an enable flag. The synthesized frequency is the input frequency times (multiplier + 1), divided by the divider. When either the multiplier or the divider is zero, that path is turned off.

When a write changes the multiplier or the divider, the block re-arms a wait counter. This counter runs on a separate slow clock. Once the programmed number of slow-clock cycles has passed, the counter raises a lock flag. The flag is brought back to the bus clock, where software can poll it as a status bit. Software can also enable a level interrupt that follows the flag. A write that leaves both the multiplier and the divider unchanged does not disturb the current lock state.

The write request crosses into the slow domain as a toggle. The slow domain echoes an acknowledge toggle back. The bus side masks the synchronized lock flag until that echo arrives, so a stale lock level is never reported.

Top module: `pll_lock_ctrl`

## Requirements
- R1: While reset is asserted and immediately after it is released, every configuration output, pllEnable, lockStatus, irqEnOut and irqOut are zero.
- R2: A cycle with cfgWr high loads cfgMul, cfgDiv, cfgRange and cfgLockCnt together, and mulOut, divOut and rangeOut show the new values from the following bus cycle onward.
- R3: pllEnable is 1 exactly when both the stored multiplier and the stored divider are non-zero.
- R4: When a write changes the multiplier or the divider, lockStatus is 0 in the bus cycle after the write edge, even if it was 1 before.
- R5: After such a write, with lock count N and the path enabled, lockStatus stays 0 for at least N slow-clock cycles. It is 1 once N+5 slow-clock edges have passed, and it remains 1 until the next write that changes the multiplier or the divider. A later changing write restarts the count.
- R6: A lock count of zero sets the lock flag on the first slow-clock edge at which the write is seen, so lockStatus is 1 within 5 slow-clock edges.
- R7: A write that leaves both the multiplier and the divider unchanged leaves lockStatus unchanged. This holds even when the write alters the range or the lock count.
- R8: While the stored multiplier or divider is zero, lockStatus stays 0 and the counter stays idle.
- R9: irqEnWr loads irqEnData into the interrupt enable bit, which is read back on irqEnOut. irqOut is the level-sensitive AND of lockStatus and that enable bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| busClk | input | 1 | Bus-side clock |
| slowClk | input | 1 | Slow clock that times the lock wait |
| rstN | input | 1 | Asynchronous active-low reset for both domains |
| cfgWr | input | 1 | Configuration write strobe |
| cfgMul | input | 6 | Multiplier field (0 turns the path off) |
| cfgDiv | input | 8 | Divider field (0 turns the path off) |
| cfgRange | input | 2 | Output range code |
| cfgLockCnt | input | 8 | Slow-clock cycles to wait before lock |
| irqEnWr | input | 1 | Interrupt enable write strobe |
| irqEnData | input | 1 | Interrupt enable value |
| pllEnable | output | 1 | Synthesizer path enabled |
| mulOut | output | 6 | Stored multiplier |
| divOut | output | 8 | Stored divider |
| rangeOut | output | 2 | Stored range code |
| lockStatus | output | 1 | Lock status bit, bus domain |
| irqEnOut | output | 1 | Interrupt enable read-back |
| irqOut | output | 1 | Level lock interrupt |

## Verification
The hardest case to reach is a re-arm that lands while the block is already locked. In that case the synchronized lock level is still high, and only the acknowledge masking keeps lockStatus low. The stimulus first lets the block reach lock and then writes a changed multiplier or divider. The bench then checks the very next bus cycle and the whole new wait window. It also restarts the count partway through a long wait and issues unchanged writes while locked, so the lower and upper lock bounds are checked against a model that counts slow-clock edges on its own.

// File: rtl/pll_lock_pkg.sv
package pll_lock_pkg;
  localparam int MUL_W_DEF = 6;
  localparam int DIV_W_DEF = 8;
  localparam int RANGE_W_DEF = 2;
  localparam int CNT_W_DEF = 8;
  localparam int SYNC_STAGES_DEF = 2;

  typedef struct packed {
    logic loadCfg;
    logic rearm;
    logic loadIrqEn;
  } ctlStrobe_t;
endpackage

// File: rtl/pll_lock_sync.sv
module pll_lock_sync #(
  parameter int WIDTH = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : gStage
    if (g == 0) begin : gFirst
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stage[g] <= '0;
        else       stage[g] <= d;
      end
    end else begin : gNext
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stage[g] <= '0;
        else       stage[g] <= stage[g-1];
      end
    end
  end

  assign q = stage[STAGES-1];
endmodule

// File: rtl/pll_lock_ctl.sv
module pll_lock_ctl import pll_lock_pkg::*; #(
  parameter int MUL_W = MUL_W_DEF,
  parameter int DIV_W = DIV_W_DEF
) (
  input  logic             cfgWr,
  input  logic [MUL_W-1:0] cfgMul,
  input  logic [DIV_W-1:0] cfgDiv,
  input  logic [MUL_W-1:0] curMul,
  input  logic [DIV_W-1:0] curDiv,
  input  logic             irqEnWr,
  output ctlStrobe_t       strobe
);
  logic fieldChange;

  // Only the frequency-defining fields re-arm the wait counter.
  assign fieldChange = (cfgMul != curMul) || (cfgDiv != curDiv);

  always_comb begin
    strobe.loadCfg   = cfgWr;
    strobe.rearm     = cfgWr && fieldChange;
    strobe.loadIrqEn = irqEnWr;
  end
endmodule

// File: rtl/pll_lock_dp.sv
module pll_lock_dp import pll_lock_pkg::*; #(
  parameter int MUL_W = MUL_W_DEF,
  parameter int DIV_W = DIV_W_DEF,
  parameter int RANGE_W = RANGE_W_DEF,
  parameter int CNT_W = CNT_W_DEF
) (
  input  logic               busClk,
  input  logic               rstN,
  input  ctlStrobe_t         strobe,
  input  logic [MUL_W-1:0]   cfgMul,
  input  logic [DIV_W-1:0]   cfgDiv,
  input  logic [RANGE_W-1:0] cfgRange,
  input  logic [CNT_W-1:0]   cfgLockCnt,
  input  logic               irqEnData,
  input  logic               ackSync,
  input  logic               lockSync,
  output logic [MUL_W-1:0]   mulQ,
  output logic [DIV_W-1:0]   divQ,
  output logic [RANGE_W-1:0] rangeQ,
  output logic [CNT_W-1:0]   cntQ,
  output logic               enQ,
  output logic               irqEnQ,
  output logic               reqTgl,
  output logic               lockStatus,
  output logic               irqOut
);
  logic ackMatch;

  assign ackMatch = (ackSync == reqTgl);

  always_ff @(posedge busClk or negedge rstN) begin
    if (!rstN) begin
      mulQ       <= '0;
      divQ       <= '0;
      rangeQ     <= '0;
      cntQ       <= '0;
      enQ        <= 1'b0;
      irqEnQ     <= 1'b0;
      reqTgl     <= 1'b0;
      lockStatus <= 1'b0;
    end else begin
      if (strobe.loadCfg) begin
        mulQ   <= cfgMul;
        divQ   <= cfgDiv;
        rangeQ <= cfgRange;
        cntQ   <= cfgLockCnt;
        enQ    <= (cfgMul != '0) && (cfgDiv != '0);
      end
      if (strobe.rearm) reqTgl <= ~reqTgl;
      if (strobe.loadIrqEn) irqEnQ <= irqEnData;
      lockStatus <= strobe.rearm ? 1'b0 : (lockSync && ackMatch);
    end
  end

  assign irqOut = lockStatus & irqEnQ;

  // R4
  rearm_drop_chk: assert property (@(posedge busClk) disable iff (!rstN)
    strobe.rearm |=> !lockStatus);

  // R7
  steady_lock_chk: assert property (@(posedge busClk) disable iff (!rstN)
    (strobe.loadCfg && !strobe.rearm && lockStatus) |=> lockStatus);

  // R3
  enable_cfg_chk: assert property (@(posedge busClk) disable iff (!rstN)
    enQ |-> (mulQ != '0) && (divQ != '0));
endmodule

// File: rtl/pll_lock_timer.sv
module pll_lock_timer import pll_lock_pkg::*; #(
  parameter int CNT_W = CNT_W_DEF,
  parameter int SYNC_STAGES = SYNC_STAGES_DEF
) (
  input  logic             slowClk,
  input  logic             rstN,
  input  logic             reqTgl,
  input  logic             en,
  input  logic [CNT_W-1:0] lockCnt,
  output logic             lockS,
  output logic             ackTgl
);
  logic             reqS;
  logic             seenTgl;
  logic             enS;
  logic             busy;
  logic [CNT_W-1:0] remaining;
  logic             fire;

  pll_lock_sync #(.WIDTH(1), .STAGES(SYNC_STAGES)) i_reqSync (
    .clk (slowClk),
    .rstN(rstN),
    .d   (reqTgl),
    .q   (reqS)
  );

  assign fire = (reqS != seenTgl);

  // en and lockCnt are held steady by the bus side while the toggle is in flight.
  always_ff @(posedge slowClk or negedge rstN) begin
    if (!rstN) begin
      seenTgl   <= 1'b0;
      ackTgl    <= 1'b0;
      enS       <= 1'b0;
      busy      <= 1'b0;
      lockS     <= 1'b0;
      remaining <= '0;
    end else begin
      ackTgl <= seenTgl;
      if (fire) begin
        seenTgl   <= reqS;
        enS       <= en;
        remaining <= lockCnt;
        if (!en) begin
          lockS <= 1'b0;
          busy  <= 1'b0;
        end else if (lockCnt == '0) begin
          lockS <= 1'b1;
          busy  <= 1'b0;
        end else begin
          lockS <= 1'b0;
          busy  <= 1'b1;
        end
      end else if (busy) begin
        remaining <= remaining - CNT_W'(1);
        if (remaining == CNT_W'(1)) begin
          lockS <= 1'b1;
          busy  <= 1'b0;
        end
      end
    end
  end

  // R5
  count_hold_chk: assert property (@(posedge slowClk) disable iff (!rstN)
    (busy && remaining > CNT_W'(1) && !fire) |=> !lockS);

  // R5
  count_done_chk: assert property (@(posedge slowClk) disable iff (!rstN)
    (busy && remaining == CNT_W'(1) && !fire) |=> lockS);

  // R6
  zero_count_chk: assert property (@(posedge slowClk) disable iff (!rstN)
    (fire && en && lockCnt == '0) |=> lockS);

  // R8
  disabled_idle_chk: assert property (@(posedge slowClk) disable iff (!rstN)
    !enS |-> (!lockS && !busy));
endmodule

// File: rtl/pll_lock_ctrl.sv
module pll_lock_ctrl import pll_lock_pkg::*; #(
  parameter int MUL_W = MUL_W_DEF,
  parameter int DIV_W = DIV_W_DEF,
  parameter int RANGE_W = RANGE_W_DEF,
  parameter int CNT_W = CNT_W_DEF,
  parameter int SYNC_STAGES = SYNC_STAGES_DEF
) (
  input  logic               busClk,
  input  logic               slowClk,
  input  logic               rstN,
  input  logic               cfgWr,
  input  logic [MUL_W-1:0]   cfgMul,
  input  logic [DIV_W-1:0]   cfgDiv,
  input  logic [RANGE_W-1:0] cfgRange,
  input  logic [CNT_W-1:0]   cfgLockCnt,
  input  logic               irqEnWr,
  input  logic               irqEnData,
  output logic               pllEnable,
  output logic [MUL_W-1:0]   mulOut,
  output logic [DIV_W-1:0]   divOut,
  output logic [RANGE_W-1:0] rangeOut,
  output logic               lockStatus,
  output logic               irqEnOut,
  output logic               irqOut
);
  ctlStrobe_t       strobe;
  logic [CNT_W-1:0] cntQ;
  logic             reqTgl;
  logic             lockS;
  logic             ackTgl;
  logic [1:0]       backSync;

  pll_lock_ctl #(.MUL_W(MUL_W), .DIV_W(DIV_W)) i_ctl (
    .cfgWr  (cfgWr),
    .cfgMul (cfgMul),
    .cfgDiv (cfgDiv),
    .curMul (mulOut),
    .curDiv (divOut),
    .irqEnWr(irqEnWr),
    .strobe (strobe)
  );

  pll_lock_dp #(.MUL_W(MUL_W), .DIV_W(DIV_W), .RANGE_W(RANGE_W), .CNT_W(CNT_W)) i_dp (
    .busClk    (busClk),
    .rstN      (rstN),
    .strobe    (strobe),
    .cfgMul    (cfgMul),
    .cfgDiv    (cfgDiv),
    .cfgRange  (cfgRange),
    .cfgLockCnt(cfgLockCnt),
    .irqEnData (irqEnData),
    .ackSync   (backSync[1]),
    .lockSync  (backSync[0]),
    .mulQ      (mulOut),
    .divQ      (divOut),
    .rangeQ    (rangeOut),
    .cntQ      (cntQ),
    .enQ       (pllEnable),
    .irqEnQ    (irqEnOut),
    .reqTgl    (reqTgl),
    .lockStatus(lockStatus),
    .irqOut    (irqOut)
  );

  pll_lock_timer #(.CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)) i_timer (
    .slowClk(slowClk),
    .rstN   (rstN),
    .reqTgl (reqTgl),
    .en     (pllEnable),
    .lockCnt(cntQ),
    .lockS  (lockS),
    .ackTgl (ackTgl)
  );

  pll_lock_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) i_backSync (
    .clk (busClk),
    .rstN(rstN),
    .d   ({ackTgl, lockS}),
    .q   (backSync)
  );

  // R9
  irq_gate_chk: assert property (@(posedge busClk) disable iff (!rstN)
    $rose(irqOut) |-> irqEnOut);
endmodule

// File: tb/test_pll_lock_ctrl.sv
module test_pll_lock_ctrl;
  logic       busClk = 0;
  logic       slowClk = 0;
  logic       rstN = 0;
  logic       cfgWr = 0;
  logic [5:0] cfgMul = '0;
  logic [7:0] cfgDiv = '0;
  logic [1:0] cfgRange = '0;
  logic [7:0] cfgLockCnt = '0;
  logic       irqEnWr = 0;
  logic       irqEnData = 0;
  logic       pllEnable, lockStatus, irqEnOut, irqOut;
  logic [5:0] mulOut;
  logic [7:0] divOut;
  logic [1:0] rangeOut;

  int checks = 0;
  int fails = 0;
  bit checking = 0;
  bit done = 0;

  // reference model state
  int mMul = 0, mDiv = 0, mRng = 0, armCnt = 0;
  bit mEn = 0, mIrqEn = 0, justWrote = 0, steady = 0;
  int slowSince = 1000;

  always #10 busClk = ~busClk;
  always #83 slowClk = ~slowClk;

  pll_lock_ctrl i_pll_lock_ctrl (
    .busClk(busClk), .slowClk(slowClk), .rstN(rstN),
    .cfgWr(cfgWr), .cfgMul(cfgMul), .cfgDiv(cfgDiv), .cfgRange(cfgRange),
    .cfgLockCnt(cfgLockCnt), .irqEnWr(irqEnWr), .irqEnData(irqEnData),
    .pllEnable(pllEnable), .mulOut(mulOut), .divOut(divOut), .rangeOut(rangeOut),
    .lockStatus(lockStatus), .irqEnOut(irqEnOut), .irqOut(irqOut)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge slowClk) if (slowSince < 1000) slowSince++;

  // per-cycle comparison against the model
  always @(negedge busClk) begin
    if (checking) begin
      check(mulOut == mMul[5:0] && divOut == mDiv[7:0] && rangeOut == mRng[1:0],
            "R2 config outputs", {mulOut, divOut, rangeOut}, mMul * 1024 + mDiv * 4 + mRng);
      check(pllEnable == mEn, "R3 pllEnable", pllEnable, mEn);
      check(irqEnOut == mIrqEn, "R9 irqEnOut", irqEnOut, mIrqEn);
      check(irqOut == (lockStatus && mIrqEn), "R9 irqOut", irqOut, lockStatus && mIrqEn);
      if (justWrote) begin
        check(lockStatus == 0, "R4 lock drop after change", lockStatus, 0);
        justWrote = 0;
      end else if (!mEn) begin
        check(lockStatus == 0, "R8 lock while disabled", lockStatus, 0);
      end else if (slowSince < armCnt) begin
        check(lockStatus == 0, "R5 lock early", lockStatus, 0);
      end else if (slowSince >= armCnt + 5) begin
        if (steady)           check(lockStatus == 1, "R7 lock kept", lockStatus, 1);
        else if (armCnt == 0) check(lockStatus == 1, "R6 zero count lock", lockStatus, 1);
        else                  check(lockStatus == 1, "R5 lock late", lockStatus, 1);
      end
    end
  end

  task automatic cfgWrite(input int mul, input int div, input int rng, input int cnt);
    bit changed;
    @(negedge busClk);
    cfgWr = 1; cfgMul = mul[5:0]; cfgDiv = div[7:0];
    cfgRange = rng[1:0]; cfgLockCnt = cnt[7:0];
    @(posedge busClk);
    changed = (mul != mMul) || (div != mDiv);
    mMul = mul; mDiv = div; mRng = rng;
    mEn = (mul != 0) && (div != 0);
    steady = !changed;
    if (changed) begin
      armCnt = cnt;
      slowSince = 0;
      justWrote = 1;
    end
    @(negedge busClk);
    cfgWr = 0;
  endtask

  task automatic irqWrite(input bit v);
    @(negedge busClk);
    irqEnWr = 1; irqEnData = v;
    @(posedge busClk);
    mIrqEn = v;
    @(negedge busClk);
    irqEnWr = 0;
  endtask

  task automatic waitSlow(input int n);
    repeat (n) @(posedge slowClk);
    @(negedge busClk);
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #4000000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      finishRun();
    end
  end

  initial begin
    // R1: reset state while held and after release
    repeat (3) @(negedge busClk);
    check(!pllEnable && mulOut == 0 && divOut == 0 && rangeOut == 0,
          "R1 config in reset", {pllEnable, mulOut, divOut, rangeOut}, 0);
    check(!lockStatus && !irqEnOut && !irqOut, "R1 status in reset",
          {lockStatus, irqEnOut, irqOut}, 0);
    rstN = 1;
    @(negedge busClk);
    check(!lockStatus && !pllEnable && !irqOut, "R1 after release",
          {lockStatus, pllEnable, irqOut}, 0);
    checking = 1;
    waitSlow(3);

    // R9: enable interrupt
    irqWrite(1);

    // R5: mul 3, count 6
    cfgWrite(3, 2, 1, 6);
    waitSlow(12);
    check(lockStatus == 1, "R5 locked after count 6", lockStatus, 1);
    check(irqOut == 1, "R9 irq with lock", irqOut, 1);

    // R7: same mul/div, other range and count
    cfgWrite(3, 2, 2, 20);
    waitSlow(8);
    check(lockStatus == 1, "R7 unchanged write", lockStatus, 1);

    // R4/R6: change multiplier while locked, count zero
    cfgWrite(5, 2, 2, 0);
    waitSlow(8);
    check(lockStatus == 1, "R6 zero count", lockStatus, 1);

    // R8: divider zero disables
    cfgWrite(5, 0, 3, 2);
    waitSlow(15);
    check(lockStatus == 0 && pllEnable == 0, "R8 div zero", {lockStatus, pllEnable}, 0);
    cfgWrite(0, 9, 0, 1);
    waitSlow(15);
    check(lockStatus == 0 && pllEnable == 0, "R8 mul zero", {lockStatus, pllEnable}, 0);

    // R3/R5: extreme fields, interrupt disabled
    cfgWrite(62, 255, 1, 3);
    irqWrite(0);
    waitSlow(10);
    check(lockStatus == 1 && irqOut == 0, "R9 irq masked", {lockStatus, irqOut}, 2);

    // R5: restart in the middle of a long wait
    cfgWrite(10, 4, 0, 40);
    waitSlow(12);
    check(lockStatus == 0, "R5 mid count", lockStatus, 0);
    cfgWrite(10, 5, 0, 12);
    waitSlow(10);
    check(lockStatus == 0, "R5 restarted count", lockStatus, 0);
    irqWrite(1);
    waitSlow(10);
    check(lockStatus == 1 && irqOut == 1, "R5 restarted lock", {lockStatus, irqOut}, 3);

    done = 1;
    finishRun();
  end
endmodule